// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Shared Top Pin

This block is one 8-bit general-purpose I/O port. It has a data register, a direction register and a small function selector for its highest pin. A register bus reads and writes the two registers through a request channel and a read-response channel. Both channels use valid/ready. Each pin drives an output value and an output enable toward its pad and samples the pad level back through a two-stage synchronizer.

Bit 6 is a read-only status bit. It latches the synchronized level of its own pad once after reset, and it never drives its pad. Bit 7 is shared. In single-chip mode it is always a plain I/O bit. In extended mode it can become a wait input or a chip-select output. The choice follows a fixed priority: first the wait-mode bits, then the chip-select enable, then the direction bit. The chip-select and wait controllers are outside this block. They appear here only as plain control pins.

Back-pressure: a request is taken on a cycle where `req_valid` and `req_ready` are both high. A read places its result in a one-entry response register. That register is held until `rsp_ready` is high. `req_ready` is low only while a response is waiting and `rsp_ready` is low.

Top module: `gpio8_port`

## Requirements
- R1: During and right after reset, the direction register and every writable data bit are 0, `pad_oe` is all 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write with `req_addr`=0 loads bits 7..0 of the data register from `req_wdata`, except bit 6. The bit-6 write data is ignored.
- R3: A write with `req_addr`=1 loads the direction register (1 = output) on the same clock edge. For bits 0..5, `pad_oe[i]` equals direction bit i and `pad_out[i]` equals data bit i.
- R4: A read with `req_addr`=0 returns, for each bit, the data-register value when its direction bit is 1. When the direction bit is 0 it returns the pad level after two synchronizer flops. A read with `req_addr`=1 returns the direction register.
- R5: Bit 6 of the data register is read-only. On the third rising edge after reset release it captures the synchronized `pad_in[6]` level and then holds it. `pad_oe[6]` is always 0.
- R6: With `mode_ext`=0, pin 7 behaves as a plain I/O bit: `pad_oe[7]` is direction bit 7 and `pad_out[7]` is data bit 7. `wait_sel_a`, `wait_sel_b` and `cs_en` have no effect, and `wait_out` is 0.
- R7: With `mode_ext`=1 and `wait_sel_a` or `wait_sel_b` high, pin 7 is the wait input: `pad_oe[7]` is 0 and `wait_out` is the synchronized `pad_in[7]` level, whatever `cs_en` and the direction bit are.
- R8: With `mode_ext`=1, both wait selects 0 and `cs_en`=1, pin 7 is the chip-select output: `pad_oe[7]` is 1 and `pad_out[7]` follows `cs_n_in`.
- R9: With `mode_ext`=1, both wait selects 0 and `cs_en`=0, pin 7 is plain I/O controlled by direction bit 7 and data bit 7.
- R10: A read that is accepted sets `rsp_valid` on the next edge. The result stays stable until `rsp_ready` is high. `req_ready` is `!rsp_valid || rsp_ready`. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 1 = extended mode, 0 = single-chip mode |
| wait_sel_a | input | 1 | First wait-mode select |
| wait_sel_b | input | 1 | Second wait-mode select |
| cs_en | input | 1 | Chip-select output enable for pin 7 |
| cs_n_in | input | 1 | Chip-select level from the external controller |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = data register, 1 = direction register |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| wait_out | output | 1 | Synchronized wait level when pin 7 is the wait input |

## Verification
Two things can happen in the same cycle: a new read request can be accepted on the very edge where the previous response is taken. The bench provokes this with a burst of back-to-back reads while `rsp_ready` stays high. The scoreboard queue then has to match every response, in order, against the value computed for it when it was issued. The opposite case is also driven: a response is held while `rsp_ready` is low and the pads change. During that stall `rsp_data` must stay frozen and `req_ready` must stay low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    PF_GPIO = 2'd0,
    PF_WAIT = 2'd1,
    PF_CS   = 2'd2
  } pin_fn_e;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // STAGES must be at least 2
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W           = 8,
  parameter int RO_BIT      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic         req_addr,
  input  logic [W-1:0] req_wdata,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);
  localparam int FILL_W = $clog2(SYNC_STAGES + 1);

  logic [W-1:0]      gp_q;
  logic              ro_q;
  logic              cap_done;
  logic [FILL_W-1:0] fill;
  logic [W-1:0]      wr_mask;
  logic [W-1:0]      rd_val;
  logic              accept;

  always_comb begin
    wr_mask         = '1;
    wr_mask[RO_BIT] = 1'b0;
  end

  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;
  assign data_q    = (gp_q & wr_mask) | ({W{ro_q}} & ~wr_mask);

  always_comb begin
    if (req_addr == ADDR_DIR) rd_val = dir_q;
    else                      rd_val = (dir_q & data_q) | (~dir_q & pin_sync);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_q      <= '0;
      dir_q     <= '0;
      ro_q      <= 1'b0;
      cap_done  <= 1'b0;
      fill      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (!cap_done) begin
        if (fill == FILL_W'(SYNC_STAGES)) begin
          ro_q     <= pin_sync[RO_BIT];
          cap_done <= 1'b1;
        end else begin
          fill <= fill + 1'b1;
        end
      end
      if (accept && req_write) begin
        if (req_addr == ADDR_DIR) dir_q <= req_wdata;
        else                      gp_q  <= req_wdata & wr_mask;
      end
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_val;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R10
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_write |=> rsp_valid);

  // R3
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && (req_addr == ADDR_DIR) |=> dir_q == $past(req_wdata));

  // R5
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> $stable(data_q[RO_BIT]));
endmodule

// File: rtl/gpio_alt_sel.sv
module gpio_alt_sel
  import gpio_pkg::*;
(
  input  logic mode_ext,
  input  logic wait_sel_a,
  input  logic wait_sel_b,
  input  logic cs_en,
  input  logic cs_n_in,
  input  logic dir_bit,
  input  logic data_bit,
  input  logic pin_sync_bit,
  output logic oe,
  output logic out,
  output logic wait_out
);
  pin_fn_e fn;

  always_comb begin
    if (!mode_ext)                    fn = PF_GPIO;
    else if (wait_sel_a | wait_sel_b) fn = PF_WAIT;
    else if (cs_en)                   fn = PF_CS;
    else                              fn = PF_GPIO;
  end

  always_comb begin
    oe       = 1'b0;
    out      = 1'b0;
    wait_out = 1'b0;
    unique case (fn)
      PF_WAIT: wait_out = pin_sync_bit;
      PF_CS: begin
        oe  = 1'b1;
        out = cs_n_in;
      end
      default: begin
        oe  = dir_bit;
        out = data_bit;
      end
    endcase
  end
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port #(
  parameter int W           = 8,
  parameter int RO_BIT      = 6,
  parameter int ALT_BIT     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_ext,
  input  logic         wait_sel_a,
  input  logic         wait_sel_b,
  input  logic         cs_en,
  input  logic         cs_n_in,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic         req_addr,
  input  logic [W-1:0] req_wdata,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         wait_out
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic         alt_oe;
  logic         alt_out;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.W(W), .RO_BIT(RO_BIT), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pin_sync(pin_sync), .data_q(data_q), .dir_q(dir_q)
  );

  gpio_alt_sel u_alt (
    .mode_ext(mode_ext), .wait_sel_a(wait_sel_a), .wait_sel_b(wait_sel_b),
    .cs_en(cs_en), .cs_n_in(cs_n_in),
    .dir_bit(dir_q[ALT_BIT]), .data_bit(data_q[ALT_BIT]),
    .pin_sync_bit(pin_sync[ALT_BIT]),
    .oe(alt_oe), .out(alt_out), .wait_out(wait_out)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i == ALT_BIT) begin : g_alt
      assign pad_oe[i]  = alt_oe;
      assign pad_out[i] = alt_out;
    end else if (i == RO_BIT) begin : g_ro
      assign pad_oe[i]  = 1'b0;
      assign pad_out[i] = 1'b0;
    end else begin : g_gp
      assign pad_oe[i]  = dir_q[i];
      assign pad_out[i] = data_q[i];
    end
  end

  // R7
  wait_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ext && (wait_sel_a || wait_sel_b) |-> !pad_oe[ALT_BIT] && (wait_out == pin_sync[ALT_BIT]));

  // R8
  cs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ext && !wait_sel_a && !wait_sel_b && cs_en |-> pad_oe[ALT_BIT] && (pad_out[ALT_BIT] == cs_n_in));

  // R6
  single_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ext |-> !wait_out && (pad_oe[ALT_BIT] == dir_q[ALT_BIT]));

  // R5
  ro_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_q[RO_BIT]) |-> !pad_oe[RO_BIT]);
endmodule

// File: tb/gpio8_port_tb.sv
`timescale 1ns/1ps
module gpio8_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ext = 1'b0, wait_sel_a = 1'b0, wait_sel_b = 1'b0;
  logic       cs_en = 1'b0, cs_n_in = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, req_addr = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_ready = 1'b1;
  logic [7:0] pad_in = 8'h40;
  logic       req_ready, rsp_valid, wait_out;
  logic [7:0] rsp_data, pad_out, pad_oe;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] m_gp = '0, m_dir = '0;
  logic       m_ro = 1'b1;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  gpio8_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .wait_sel_a(wait_sel_a),
    .wait_sel_b(wait_sel_b), .cs_en(cs_en), .cs_n_in(cs_n_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .wait_out(wait_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic addr);
    logic [7:0] dv;
    dv = (m_gp & 8'hBF) | ({7'd0, m_ro} << 6);
    if (addr) return m_dir;
    return (m_dir & dv) | (~m_dir & pad_in);
  endfunction

  task automatic bus(input logic wr, input logic addr, input logic [7:0] wd, input string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    if (wr) begin
      if (addr) m_dir = wd; else m_gp = wd & 8'hBF;
    end else begin
      exp_q.push_back(model_read(addr));
      tag_q.push_back(tag);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic burst(input int n, input string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0;
    for (int k = 0; k < n; k++) begin
      req_addr = k[0];
      exp_q.push_back(model_read(req_addr));
      tag_q.push_back(tag);
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 actual=unexpected response %0h expected=none", rsp_data);
      end else begin
        chk(tag_q.pop_front(), {24'd0, rsp_data}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 oe in reset", {24'd0, pad_oe}, 32'h0);
    chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'h1);
    chk("R1 oe after reset", {24'd0, pad_oe}, 32'h0);
    settle(6);
    bus(1'b0, 1'b1, 8'h00, "R1 dir read");
    bus(1'b0, 1'b0, 8'h00, "R4 pad read 40");
    pad_in = 8'hA5; settle(3);
    bus(1'b0, 1'b0, 8'h00, "R4 pad read A5");
    // R2 / R5: write with bit 6 clear, captured bit 6 must stay 1
    bus(1'b1, 1'b1, 8'hFF, "R3 dir write");
    bus(1'b1, 1'b0, 8'h81, "R2 data write");
    bus(1'b0, 1'b0, 8'h00, "R2 R5 latched read");
    @(negedge clk);
    chk("R3 R5 oe all out", {24'd0, pad_oe}, 32'hBF);
    chk("R3 R6 pad_out", {24'd0, pad_out}, 32'h81);
    bus(1'b1, 1'b0, 8'hFF, "R2 data write ff");
    bus(1'b0, 1'b0, 8'h00, "R2 R5 read after ff");
    @(negedge clk);
    chk("R5 pad_oe6 low", {31'd0, pad_oe[6]}, 32'h0);
    bus(1'b1, 1'b0, 8'h81, "R2 restore");
    // R4 mixed direction
    bus(1'b1, 1'b1, 8'h0F, "R3 dir 0f");
    bus(1'b0, 1'b0, 8'h00, "R4 mixed read");
    // R6 single-chip ignores wait and chip-select controls
    wait_sel_a = 1'b1; cs_en = 1'b1;
    @(negedge clk);
    chk("R6 oe7 follows dir0", {31'd0, pad_oe[7]}, 32'h0);
    chk("R6 wait_out low", {31'd0, wait_out}, 32'h0);
    bus(1'b1, 1'b1, 8'h8F, "R3 dir 8f");
    @(negedge clk);
    chk("R6 oe7 follows dir1", {31'd0, pad_oe[7]}, 32'h1);
    chk("R6 out7 data", {31'd0, pad_out[7]}, 32'h1);
    // R7 wait input
    wait_sel_a = 1'b0; wait_sel_b = 1'b1; mode_ext = 1'b1;
    @(negedge clk);
    chk("R7 oe7 low", {31'd0, pad_oe[7]}, 32'h0);
    chk("R7 wait high", {31'd0, wait_out}, 32'h1);
    pad_in = 8'h25; settle(3);
    @(negedge clk);
    chk("R7 wait low", {31'd0, wait_out}, 32'h0);
    // R8 chip select
    wait_sel_b = 1'b0; cs_n_in = 1'b0;
    @(negedge clk);
    chk("R8 oe7 high", {31'd0, pad_oe[7]}, 32'h1);
    chk("R8 out7 cs low", {31'd0, pad_out[7]}, 32'h0);
    cs_n_in = 1'b1;
    @(negedge clk);
    chk("R8 out7 cs high", {31'd0, pad_out[7]}, 32'h1);
    // R9 plain I/O in extended mode
    cs_en = 1'b0; cs_n_in = 1'b0;
    @(negedge clk);
    chk("R9 oe7 dir", {31'd0, pad_oe[7]}, 32'h1);
    chk("R9 out7 data", {31'd0, pad_out[7]}, 32'h1);
    chk("R9 wait_out low", {31'd0, wait_out}, 32'h0);
    bus(1'b1, 1'b1, 8'h0F, "R9 dir 0f");
    @(negedge clk);
    chk("R9 oe7 off", {31'd0, pad_oe[7]}, 32'h0);
    // R10 writes give no response
    chk("R10 no write response", {31'd0, rsp_valid}, 32'h0);
    // R10 back-pressure while pads change
    rsp_ready = 1'b0;
    bus(1'b0, 1'b0, 8'h00, "R10 stalled read");
    @(negedge clk);
    held = rsp_data;
    chk("R10 valid held", {31'd0, rsp_valid}, 32'h1);
    pad_in = 8'h5A; settle(3);
    @(negedge clk);
    chk("R10 data frozen", {24'd0, rsp_data}, {24'd0, held});
    chk("R10 ready low", {31'd0, req_ready}, 32'h0);
    @(posedge clk); #1 rsp_ready = 1'b1;
    settle(2);
    // R10 accept in same cycle as pop
    burst(6, "R10 R4 burst");
    settle(4);
    chk("R10 queue drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule